// File: doc/BRIEF.md
# Command Ring Producer with Doorbell

This block is the host side of a command ring. A caller hands it one fixed-size command descriptor at a time over a valid/ready handshake. The block stores the descriptor in the next free slot of a circular ring and tags it with the caller's nonzero identifier. It then decides whether the device needs a "new command" doorbell.

Word 0 of each slot is the ownership word. A nonzero word 0 means the slot holds a posted command. The device, modelled here by a consumer port, takes the command and then clears word 0 back to zero. The producer always writes every other word of a descriptor before word 0, so a device that polls word 0 never sees a half-written slot.

The block remembers the two slots it filled most recently. After each post it rings the doorbell only if at least one of those two slots has already been emptied by the device. If both are still occupied, the device is still working through the ring, and the extra doorbell is suppressed.

Top module: `cmd_ring_producer`

## Requirements
- R1: For an accepted command, word k (1 ≤ k < WORDS) of the slot it lands in equals bits [32k+31:32k] of `cmd_data`. A consumer read of (slot, word) returns that word on `cons_rdata` one clock after the edge that samples `cons_rd_en`.
- R2: Word 0 of a posted slot holds the caller's identifier in bits [IDW-1:0]. Its upper bits [31:IDW] are taken from bits [31:IDW] of `cmd_data`.
- R3: Word 0 is written last. It reads zero while the body words are being written, and it changes on the WORDS-th clock edge after the edge that accepted the command.
- R4: `cmd_ready` is high only when no post is in progress and word 0 of the next slot reads zero. After an accepting edge it stays low for WORDS+1 cycles.
- R5: Successive posts fill slots 0, 1, …, SLOTS-1 and then wrap back to slot 0.
- R6: The doorbell is a one-cycle pulse, high during the cycle after the (WORDS+1)-th edge that follows acceptance. It fires when word 0 of either of the two previously filled slots reads zero in the cycle before that edge.
- R7: The first post after reset always rings the doorbell.
- R8: No doorbell is raised when word 0 of both previously filled slots is nonzero.
- R9: A consumer clear sets word 0 of the named slot to zero from the next edge. If the producer writes word 0 of the same slot on the same edge, the producer's write wins.
- R10: After reset, `cmd_ready` is high, the doorbell is low, and word 0 of every slot reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Caller offers a command |
| cmd_ready | output | 1 | Block can accept a command this cycle |
| cmd_id | input | IDW | Nonzero identifier for the command |
| cmd_data | input | WORDS*DW | Descriptor; word k sits at bits [DW*k+DW-1:DW*k] |
| ring_doorbell | output | 1 | One-cycle "new command" pulse to the device |
| cons_rd_en | input | 1 | Consumer read request |
| cons_slot | input | log2(SLOTS) | Slot to read |
| cons_word | input | log2(WORDS) | Word to read within the slot |
| cons_rdata | output | DW | Read data, one cycle after the request |
| cons_clr | input | 1 | Consumer releases a slot |
| cons_clr_slot | input | log2(SLOTS) | Slot whose word 0 is cleared |

## Verification
The bound checker watches four properties on every cycle:
- an accepted command drops `cmd_ready` on the next cycle;
- the doorbell never lasts more than one cycle, and it only follows a word-0 write by two cycles;
- every word-0 write is directly preceded by the write of the last body word to the same slot;
- the slot pointer only ever steps by one, wrapping at the end of the ring.

Other behaviours depend on what the device has consumed, and only the bench's scenarios can show them. These are whether a given post rings the doorbell or is suppressed, the stall when the ring is full, and the stored word contents seen through the consumer port. The bench sets them up with chosen patterns of clears against a behavioural ring model.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BODY = 2'd1,
    PH_HEAD = 2'd2,
    PH_RING = 2'd3
  } phase_t;
endpackage

// File: rtl/ring_body_ram.sv
// Descriptor body storage: one write port for the producer, one registered
// read port for the consumer, laid out for block RAM inference.
module ring_body_ram #(
  parameter int SLOTS = 16,
  parameter int WORDS = 16,
  parameter int DW    = 32,
  localparam int SW   = $clog2(SLOTS),
  localparam int WW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [SW-1:0] wslot,
  input  logic [WW-1:0] wword,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [SW-1:0] rslot,
  input  logic [WW-1:0] rword,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = SLOTS * WORDS;
  localparam int AW    = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] waddr, raddr;

  assign waddr = AW'(wslot) * AW'(WORDS) + AW'(wword);
  assign raddr = AW'(rslot) * AW'(WORDS) + AW'(rword);

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ring_head_file.sv
// Ownership words (word 0 of every slot) kept in flops: the producer needs
// three simultaneous reads and the consumer needs its own clear and read.
module ring_head_file #(
  parameter int SLOTS = 16,
  parameter int DW    = 32,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [SW-1:0] set_slot,
  input  logic [DW-1:0] set_data,
  input  logic          clr_en,
  input  logic [SW-1:0] clr_slot,
  input  logic [SW-1:0] rd_a_slot,
  output logic [DW-1:0] rd_a_data,
  input  logic [SW-1:0] rd_b_slot,
  output logic [DW-1:0] rd_b_data,
  input  logic [SW-1:0] rd_c_slot,
  output logic [DW-1:0] rd_c_data,
  input  logic          cons_re,
  input  logic [SW-1:0] cons_slot,
  output logic [DW-1:0] cons_q
);
  logic [DW-1:0] head [SLOTS];

  assign rd_a_data = head[rd_a_slot];
  assign rd_b_data = head[rd_b_slot];
  assign rd_c_data = head[rd_c_slot];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SLOTS; s++) head[s] <= '0;
      cons_q <= '0;
    end else begin
      if (cons_re) cons_q <= head[cons_slot];
      if (clr_en)  head[clr_slot] <= '0;
      if (set_en)  head[set_slot] <= set_data;  // producer wins on a clash
    end
  end
endmodule

// File: rtl/ring_post_ctrl.sv
// Posting sequencer: body words one per cycle, then word 0, then the
// doorbell decision and the pointer/history update.
module ring_post_ctrl
  import cmd_ring_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int WORDS = 16,
  parameter int DW    = 32,
  parameter int IDW   = 16,
  localparam int SW   = $clog2(SLOTS),
  localparam int WW   = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [IDW-1:0]      cmd_id,
  input  logic [WORDS*DW-1:0] cmd_data,
  input  logic [DW-1:0]       next_w0,
  input  logic [DW-1:0]       hnew_w0,
  input  logic [DW-1:0]       hold_w0,
  output logic                body_we,
  output logic [SW-1:0]       body_slot,
  output logic [WW-1:0]       body_word,
  output logic [DW-1:0]       body_wdata,
  output logic                head_we,
  output logic [SW-1:0]       head_slot,
  output logic [DW-1:0]       head_wdata,
  output logic [SW-1:0]       next_slot,
  output logic [SW-1:0]       hist_new,
  output logic [SW-1:0]       hist_old,
  output logic                doorbell
);
  phase_t              ph;
  logic [WORDS*DW-1:0] pay_q;
  logic [IDW-1:0]      id_q;
  logic [SW-1:0]       nxt_q, hnew_q, hold_q;
  logic [WW-1:0]       widx_q;
  logic                bell_q;

  assign cmd_ready  = (ph == PH_IDLE) && (next_w0 == '0);
  assign body_we    = (ph == PH_BODY);
  assign body_slot  = nxt_q;
  assign body_word  = widx_q;
  assign body_wdata = pay_q[widx_q*DW +: DW];
  assign head_we    = (ph == PH_HEAD);
  assign head_slot  = nxt_q;
  assign head_wdata = {pay_q[DW-1:IDW], id_q};
  assign next_slot  = nxt_q;
  assign hist_new   = hnew_q;
  assign hist_old   = hold_q;
  assign doorbell   = bell_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      pay_q  <= '0;
      id_q   <= '0;
      nxt_q  <= '0;
      hnew_q <= SW'(SLOTS - 1);
      hold_q <= SW'(SLOTS - 1);
      widx_q <= WW'(1);
      bell_q <= 1'b0;
    end else begin
      bell_q <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (cmd_valid && cmd_ready) begin
            pay_q  <= cmd_data;
            id_q   <= cmd_id;
            widx_q <= WW'(1);
            ph     <= PH_BODY;
          end
        end
        PH_BODY: begin
          if (widx_q == WW'(WORDS - 1)) ph <= PH_HEAD;
          else widx_q <= widx_q + 1'b1;
        end
        PH_HEAD: ph <= PH_RING;
        PH_RING: begin
          bell_q <= (hnew_w0 == '0) || (hold_w0 == '0);
          hold_q <= hnew_q;
          hnew_q <= nxt_q;
          nxt_q  <= (nxt_q == SW'(SLOTS - 1)) ? '0 : nxt_q + 1'b1;
          ph     <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_ring_producer.sv
module cmd_ring_producer #(
  parameter int SLOTS = 16,
  parameter int WORDS = 16,
  parameter int DW    = 32,
  parameter int IDW   = 16,
  localparam int SW   = $clog2(SLOTS),
  localparam int WW   = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [IDW-1:0]      cmd_id,
  input  logic [WORDS*DW-1:0] cmd_data,
  output logic                ring_doorbell,
  input  logic                cons_rd_en,
  input  logic [SW-1:0]       cons_slot,
  input  logic [WW-1:0]       cons_word,
  output logic [DW-1:0]       cons_rdata,
  input  logic                cons_clr,
  input  logic [SW-1:0]       cons_clr_slot
);
  logic          body_we, head_we;
  logic [SW-1:0] body_slot, head_slot, next_slot, hist_new, hist_old;
  logic [WW-1:0] body_word;
  logic [DW-1:0] body_wdata, head_wdata;
  logic [DW-1:0] next_w0, hnew_w0, hold_w0;
  logic [DW-1:0] ram_q, head_q;
  logic          rd_head_q;
  logic          rd_is_head;

  assign rd_is_head = (cons_word == '0);

  ring_post_ctrl #(
    .SLOTS(SLOTS), .WORDS(WORDS), .DW(DW), .IDW(IDW)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_id(cmd_id), .cmd_data(cmd_data),
    .next_w0(next_w0), .hnew_w0(hnew_w0), .hold_w0(hold_w0),
    .body_we(body_we), .body_slot(body_slot), .body_word(body_word),
    .body_wdata(body_wdata),
    .head_we(head_we), .head_slot(head_slot), .head_wdata(head_wdata),
    .next_slot(next_slot), .hist_new(hist_new), .hist_old(hist_old),
    .doorbell(ring_doorbell)
  );

  ring_body_ram #(
    .SLOTS(SLOTS), .WORDS(WORDS), .DW(DW)
  ) u_body (
    .clk(clk),
    .we(body_we), .wslot(body_slot), .wword(body_word), .wdata(body_wdata),
    .re(cons_rd_en && !rd_is_head), .rslot(cons_slot), .rword(cons_word),
    .rdata(ram_q)
  );

  ring_head_file #(
    .SLOTS(SLOTS), .DW(DW)
  ) u_head (
    .clk(clk), .rst(rst),
    .set_en(head_we), .set_slot(head_slot), .set_data(head_wdata),
    .clr_en(cons_clr), .clr_slot(cons_clr_slot),
    .rd_a_slot(next_slot), .rd_a_data(next_w0),
    .rd_b_slot(hist_new),  .rd_b_data(hnew_w0),
    .rd_c_slot(hist_old),  .rd_c_data(hold_w0),
    .cons_re(cons_rd_en && rd_is_head), .cons_slot(cons_slot),
    .cons_q(head_q)
  );

  always_ff @(posedge clk) begin
    if (rst)             rd_head_q <= 1'b0;
    else if (cons_rd_en) rd_head_q <= rd_is_head;
  end

  assign cons_rdata = rd_head_q ? head_q : ram_q;
endmodule

// File: rtl/cmd_ring_producer_chk.sv
module cmd_ring_producer_chk #(
  parameter int SLOTS = 16,
  parameter int WORDS = 16,
  localparam int SW   = $clog2(SLOTS),
  localparam int WW   = $clog2(WORDS)
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          ring_doorbell,
  input logic          body_we,
  input logic [SW-1:0] body_slot,
  input logic [WW-1:0] body_word,
  input logic          head_we,
  input logic [SW-1:0] head_slot,
  input logic [SW-1:0] next_slot
);
  // R4
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R6
  doorbell_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ring_doorbell |=> !ring_doorbell);

  // R6
  doorbell_after_head_chk: assert property (@(posedge clk) disable iff (rst)
    ring_doorbell |-> $past(head_we, 2));

  // R3
  head_after_body_chk: assert property (@(posedge clk) disable iff (rst)
    head_we |-> ($past(body_we) && $past(body_word) == WW'(WORDS - 1)
                 && $past(body_slot) == head_slot));

  // R5
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    (next_slot != $past(next_slot)) |->
      (next_slot == (($past(next_slot) == SW'(SLOTS - 1)) ? SW'(0)
                     : SW'($past(next_slot) + 1'b1))));
endmodule

bind cmd_ring_producer cmd_ring_producer_chk #(
  .SLOTS(SLOTS), .WORDS(WORDS)
) u_chk (
  .clk(clk), .rst(rst),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .ring_doorbell(ring_doorbell),
  .body_we(body_we), .body_slot(body_slot), .body_word(body_word),
  .head_we(head_we), .head_slot(head_slot),
  .next_slot(next_slot)
);

// File: tb/sim_cmd_ring_producer.sv
`timescale 1ns/1ps
module sim_cmd_ring_producer;
  localparam int SLOTS = 16;
  localparam int WORDS = 16;
  localparam int DW    = 32;
  localparam int IDW   = 16;
  localparam int SW    = $clog2(SLOTS);
  localparam int WW    = $clog2(WORDS);

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                cmd_valid = 1'b0;
  logic                cmd_ready;
  logic [IDW-1:0]      cmd_id = '0;
  logic [WORDS*DW-1:0] cmd_data = '0;
  logic                ring_doorbell;
  logic                cons_rd_en = 1'b0;
  logic [SW-1:0]       cons_slot = '0;
  logic [WW-1:0]       cons_word = '0;
  logic [DW-1:0]       cons_rdata;
  logic                cons_clr = 1'b0;
  logic [SW-1:0]       cons_clr_slot = '0;

  always #2.5 clk = ~clk;

  cmd_ring_producer #(.SLOTS(SLOTS), .WORDS(WORDS), .DW(DW), .IDW(IDW)) u0 (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_id(cmd_id), .cmd_data(cmd_data),
    .ring_doorbell(ring_doorbell),
    .cons_rd_en(cons_rd_en), .cons_slot(cons_slot), .cons_word(cons_word),
    .cons_rdata(cons_rdata),
    .cons_clr(cons_clr), .cons_clr_slot(cons_clr_slot)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int db_cnt = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  // behavioural ring model
  logic [31:0] m_w0   [SLOTS];
  logic [31:0] m_body [SLOTS][WORDS];
  logic [31:0] m_pay  [WORDS];
  logic [15:0] m_id;
  int          m_next, m_h1, m_h2, m_cnt, c_now;
  bit          m_db, acc, rd_pend;
  logic [31:0] exp_rd;
  string       rd_tag = "R1";
  string       rd_tag_q = "R1";

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SLOTS; s++) m_w0[s] = '0;
      m_next = 0; m_h1 = SLOTS - 1; m_h2 = SLOTS - 1;
      m_cnt = 0; m_db = 1'b0; rd_pend = 1'b0;
    end else begin
      c_now = m_cnt;
      acc = (c_now == 0) && (m_w0[m_next] == 0) && cmd_valid;
      rd_pend = cons_rd_en;
      if (cons_rd_en) begin
        exp_rd = (cons_word == 0) ? m_w0[cons_slot] : m_body[cons_slot][cons_word];
        rd_tag_q = rd_tag;
      end
      m_db = 1'b0;
      if (c_now == WORDS + 1) begin
        m_db = (m_w0[m_h1] == 0) || (m_w0[m_h2] == 0);
        m_h2 = m_h1;
        m_h1 = m_next;
        m_next = (m_next + 1) % SLOTS;
        m_cnt = 0;
      end
      if (cons_clr) m_w0[cons_clr_slot] = '0;
      if (c_now == WORDS) begin
        m_w0[m_next] = {m_pay[0][31:16], m_id};
        for (int k = 1; k < WORDS; k++) m_body[m_next][k] = m_pay[k];
      end
      if (c_now >= 1 && c_now <= WORDS) m_cnt = c_now + 1;
      if (acc) begin
        for (int k = 0; k < WORDS; k++) m_pay[k] = cmd_data[k*32 +: 32];
        m_id = cmd_id;
        m_cnt = 1;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(cmd_ready === ((m_cnt == 0) && (m_w0[m_next] == 0)), "R4",
          32'(cmd_ready), 32'((m_cnt == 0) && (m_w0[m_next] == 0)));
      chk(ring_doorbell === m_db, "R6", 32'(ring_doorbell), 32'(m_db));
      if (rd_pend) chk(cons_rdata === exp_rd, rd_tag_q, cons_rdata, exp_rd);
      if (ring_doorbell) db_cnt++;
    end
  end

  task automatic post(input logic [15:0] id, input logic [15:0] seed);
    db_cnt = 0;
    while (cmd_ready !== 1'b1) @(negedge clk);
    #1;
    cmd_id = id;
    for (int k = 0; k < WORDS; k++) cmd_data[k*32 +: 32] = {seed, 8'(k), 8'h5a};
    cmd_valid = 1'b1;
    @(negedge clk); #1;
    cmd_valid = 1'b0;
    repeat (WORDS + 2) @(negedge clk);
    #1;
  endtask

  task automatic rd(input int slot, input int word, input string tag);
    rd_tag = tag;
    cons_slot = SW'(slot);
    cons_word = WW'(word);
    cons_rd_en = 1'b1;
    @(negedge clk); #1;
    cons_rd_en = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic clr(input int slot);
    cons_clr_slot = SW'(slot);
    cons_clr = 1'b1;
    @(negedge clk); #1;
    cons_clr = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1;
    rst = 1'b0;
    cmp_on = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(cmd_ready === 1'b1, "R10", 32'(cmd_ready), 32'd1);
    chk(ring_doorbell === 1'b0, "R10", 32'(ring_doorbell), 32'd0);
    #1;
    rd(3, 0, "R10");

    // R3: word 0 of slot 0 still zero mid-post; R7: first post rings
    fork
      post(16'h0001, 16'h1111);
      begin repeat (6) @(negedge clk); #1; rd(0, 0, "R3"); end
    join
    chk(db_cnt == 1, "R7", 32'(db_cnt), 32'd1);
    rd(0, 0, "R2");
    rd(0, 5, "R1");
    rd(0, WORDS - 1, "R1");

    post(16'h0002, 16'h2222);            // slot 1: older history still empty
    chk(db_cnt == 1, "R6", 32'(db_cnt), 32'd1);
    post(16'h0003, 16'h3333);            // slot 2: both previous occupied
    chk(db_cnt == 0, "R8", 32'(db_cnt), 32'd0);
    post(16'h0004, 16'h4444);            // slot 3
    chk(db_cnt == 0, "R8", 32'(db_cnt), 32'd0);

    clr(2);
    rd(2, 0, "R9");
    post(16'h0005, 16'h5555);            // slot 4: slot 2 consumed
    chk(db_cnt == 1, "R6", 32'(db_cnt), 32'd1);

    clr(0); clr(3); clr(4);
    for (int n = 5; n < SLOTS; n++) post(16'(16'h0100 + n), 16'(16'hA000 + n));
    post(16'h0777, 16'h7777);            // wraps into slot 0
    rd(0, 0, "R5");
    rd(0, 1, "R5");

    // R4: slot 1 still occupied, ring full
    cmd_id = 16'h0888;
    for (int k = 0; k < WORDS; k++) cmd_data[k*32 +: 32] = {16'h8888, 8'(k), 8'h5a};
    cmd_valid = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(cmd_ready === 1'b0, "R4", 32'(cmd_ready), 32'd0);
    end
    #1;
    clr(1);
    while (cmd_ready !== 1'b1) @(negedge clk);
    @(negedge clk); #1;
    cmd_valid = 1'b0;
    repeat (WORDS + 2) @(negedge clk);
    #1;
    rd(1, 0, "R4");
    rd(1, 9, "R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule